// File: doc/BRIEF.md
# Clocked Serial Port with Buffer-Triggered Transfers

This block is an 8-bit synchronous serial port for a small processor bus. Software configures it through a control register. It then starts each byte transfer by touching a data register. In full-duplex mode, a write to the transmit holding register loads the shifter and starts the transfer. In receive-only mode, a read of the shift register starts the next reception, and that read returns the byte gathered last. Bits leave and arrive most-significant first. The serial clock idles high, data out changes on its falling edge, and data in is sampled on its rising edge.

As a master, the port makes the serial clock from the system clock through a power-of-two divider. As a slave, it follows an external clock and needs the active-low select input to be low before an access can start a transfer. A busy flag covers the whole transfer. A one-cycle completion pulse marks the end of each byte. The register bus has no back-pressure: every access completes in the cycle it is presented, and read data is combinational from the address. Accesses that arrive while busy are dropped. Software must poll busy, or wait for the completion pulse, before the next access.

Top module: `sio_port`

## Requirements
- R1: After reset, the control register, transmit holding register and shift register all read 0x00. Busy is 0, the completion pulse is 0, and both serial clock out and data out are 1.
- R2: The register addresses are 0 for control, 1 for transmit holding and 2 for shift; address 3 reads 0x00. Control bit 7 is enable, bit 6 is duplex (1 = transmit/receive, 0 = receive-only), bit 5 is slave, bits 2:0 are the divider select, and bits 4:3 always read 0. The shift register cannot be written.
- R3: With enable=1 and duplex=1, a write to the transmit holding register raises busy in the next cycle. The byte then goes out MSB-first on data out, and the byte arriving MSB-first on data in is left in the shift register.
- R4: With enable=1 and duplex=0, a read of the shift register returns its old contents and starts the next reception. A write to the transmit holding register in this mode only stores the byte.
- R5: With enable=0, no access starts a transfer, and writes still update the transmit holding register.
- R6: In master mode, each serial clock half-period is 2^S system cycles, where S is the divider select; a select of 7 behaves as 6. A transfer keeps busy high for 16·2^S cycles, and data out changes only on a falling serial clock edge or at the start.
- R7: The completion pulse is high for exactly one cycle: the first cycle in which busy is low after a transfer.
- R8: While busy, writes to the control and transmit holding registers are ignored, and no access starts a further transfer.
- R9: In slave mode, the external clock, select and data-in are each passed through a two-stage synchroniser. An access starts a transfer only while the synchronised select is low. Serial clock out stays high.
- R10: An access in the completion cycle is accepted and starts the next transfer at once. An access in the last busy cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 2 may start a reception) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| sck_o | output | 1 | Serial clock driven in master mode, idles high |
| sck_i | input | 1 | External serial clock used in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low slave select |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
Transfer completion and a new register access can land in the same cycle. The bench provokes this at the system clock edge where busy drops. It issues a write in the completion cycle itself and expects busy to come straight back with the new byte. It also issues a write one cycle earlier, in the last busy cycle, and expects that write to leave both the transmit holding register and busy untouched. A second overlap, a drop of a write while a divided-clock transfer runs, is judged by reading back the control and transmit holding registers after completion.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_TXBUF = 2'd1,
    REG_SHIFT = 2'd2,
    REG_NONE  = 2'd3
  } reg_addr_e;

  // Control register layout; field positions are software-visible.
  typedef struct packed {
    logic       en;
    logic       duplex;
    logic       slave;
    logic [1:0] spare;
    logic [2:0] div_sel;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sio_clkgen.sv
// Half-period tick generator for the master serial clock.
module sio_clkgen #(
  parameter int SEL_W     = 3,
  parameter int MAX_LOG2  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int CNT_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb begin
    if (sel > SEL_W'(MAX_LOG2)) begin
      limit = CNT_W'((1 << MAX_LOG2) - 1);
    end else begin
      limit = CNT_W'((1 << sel) - 1);
    end
  end

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sio_shifter.sv
// Shift register with separate output latch: sample on rise, present on fall.
module sio_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_data,
  input  logic [DATA_W-1:0] load_val,
  input  logic              sample,
  input  logic              din,
  input  logic              present,
  output logic [DATA_W-1:0] shift_q,
  output logic              dout,
  output logic              last
);

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic [CNT_W-1:0] bit_cnt;

  assign last = sample && (bit_cnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      dout    <= 1'b1;
      bit_cnt <= '0;
    end else if (load) begin
      bit_cnt <= '0;
      if (load_data) begin
        shift_q <= load_val;
        dout    <= load_val[DATA_W-1];
      end else begin
        dout    <= shift_q[DATA_W-1];
      end
    end else begin
      if (sample) begin
        shift_q <= {shift_q[DATA_W-2:0], din};
        bit_cnt <= last ? '0 : bit_cnt + 1'b1;
      end
      if (present) begin
        dout <= shift_q[DATA_W-1];
      end
    end
  end

endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SEL_W        = 3,
  parameter int MAX_DIV_LOG2 = 7,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sck_o,
  input  logic              sck_i,
  output logic              sdo,
  input  logic              sdi,
  input  logic              ss_n,
  output logic              busy,
  output logic              done_irq
);

  localparam int HALF_LOG2_MAX = MAX_DIV_LOG2 - 1;
  localparam int SYNC_W        = 3;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] txbuf_q;
  logic [DATA_W-1:0] shift_q;
  logic              busy_q;
  logic              done_q;
  logic              sck_q;

  // ---------------- slave-side synchronisers ----------------
  logic [SYNC_W-1:0] sync_out;
  logic              s_sck, s_ss_n, s_sdi, s_sck_prev;

  sio_sync #(
    .W      (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sck_i, ss_n, sdi}),
    .q    (sync_out)
  );

  assign {s_sck, s_ss_n, s_sdi} = sync_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_sck_prev <= 1'b1;
    else        s_sck_prev <= s_sck;
  end

  // ---------------- access decode and start ----------------
  logic wr_ctrl, wr_tx, rd_shift, sel_ok, start;

  assign wr_ctrl  = reg_wr && (reg_addr == REG_CTRL)  && !busy_q;
  assign wr_tx    = reg_wr && (reg_addr == REG_TXBUF) && !busy_q;
  assign rd_shift = reg_rd && (reg_addr == REG_SHIFT) && !busy_q;
  assign sel_ok   = !ctrl_q.slave || !s_ss_n;
  assign start    = ctrl_q.en && sel_ok && (ctrl_q.duplex ? wr_tx : rd_shift);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      txbuf_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q       <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        ctrl_q.spare <= '0;
      end
      if (wr_tx) txbuf_q <= reg_wdata;
    end
  end

  always_comb begin
    unique case (reg_addr)
      REG_CTRL:  reg_rdata = DATA_W'(ctrl_q);
      REG_TXBUF: reg_rdata = txbuf_q;
      REG_SHIFT: reg_rdata = shift_q;
      default:   reg_rdata = '0;
    endcase
  end

  // ---------------- master clock ----------------
  logic tick, m_fall, m_rise;

  sio_clkgen #(
    .SEL_W   (SEL_W),
    .MAX_LOG2(HALF_LOG2_MAX)
  ) u_clkgen (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q && !ctrl_q.slave),
    .sel  (ctrl_q.div_sel),
    .tick (tick)
  );

  assign m_fall = tick && sck_q;
  assign m_rise = tick && !sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sck_q <= 1'b1;
    else if (tick) sck_q <= !sck_q;
  end

  // ---------------- edge selection ----------------
  logic s_rise, s_fall, do_sample, do_present, shift_din, last;

  assign s_rise     = busy_q && ctrl_q.slave && s_sck && !s_sck_prev;
  assign s_fall     = busy_q && ctrl_q.slave && !s_sck && s_sck_prev;
  assign do_sample  = ctrl_q.slave ? s_rise : m_rise;
  assign do_present = ctrl_q.slave ? s_fall : m_fall;
  assign shift_din  = ctrl_q.slave ? s_sdi  : sdi;

  sio_shifter #(
    .DATA_W(DATA_W)
  ) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_data(ctrl_q.duplex),
    .load_val (reg_wdata),
    .sample   (do_sample),
    .din      (shift_din),
    .present  (do_present),
    .shift_q  (shift_q),
    .dout     (sdo),
    .last     (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (start)     busy_q <= 1'b1;
      else if (last) busy_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign done_irq = done_q;
  assign sck_o    = sck_q;

endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done_irq,
  input logic              sck_o,
  input logic              sdo,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [1:0]        reg_addr,
  input logic              ctrl_slave,
  input logic [DATA_W-1:0] txbuf
);

  // R7: completion is a lone pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R7: pulse lands on the first idle cycle after a transfer
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!busy && $past(busy)));

  // R3/R4: busy only rises after a start-capable access
  a_r3_start_from_access: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past((reg_wr && reg_addr == 2'd1) || (reg_rd && reg_addr == 2'd2)));

  // R8: holding register frozen against writes while busy
  a_r8_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd1) |=> $stable(txbuf));

  // R6: serial clock idles high
  a_r6_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_o);

  // R6: data out moves only on a falling serial clock or at the start
  a_r6_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctrl_slave && !$stable(sdo)) |-> ($fell(sck_o) || $rose(busy)));

  // R9: no clock driven in slave mode
  a_r9_slave_quiet_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_slave) |-> sck_o);

endmodule

bind sio_port sio_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done_irq  (done_irq),
  .sck_o     (sck_o),
  .sdo       (sdo),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .ctrl_slave(ctrl_q.slave),
  .txbuf     (txbuf_q)
);

// File: tb/sio_port_bench.sv
module sio_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sck_o, sdo, busy, done_irq;
  logic       sck_i = 1'b1, sdi = 1'b0, ss_n = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  int done_cnt = 0;

  always #2 clk = ~clk;

  always @(posedge clk) if (done_irq) done_cnt <= done_cnt + 1;

  sio_port u_sio_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck_o(sck_o), .sck_i(sck_i), .sdo(sdo), .sdi(sdi), .ss_n(ss_n),
    .busy(busy), .done_irq(done_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // Master transfer with a bench-side slave model; returns at the completion cycle + 1.
  task automatic mxfer(input logic [7:0] tx, input logic [7:0] rxpat, input bit rx_only,
                       input logic [7:0] prev_shift, input int half, input string tag);
    logic [7:0] bsr, rd;
    logic       prev;
    int         n;
    bsr = rxpat;
    sdi = bsr[7];
    if (rx_only) begin
      bus_read(2'd2, rd);
      chk({tag, " R4 read returns previous"}, rd, prev_shift);
    end else begin
      bus_write(2'd1, tx);
    end
    chk({tag, " R3 busy after start"}, busy, 1);
    n = 0;
    prev = sck_o;
    while (busy) begin
      n++;
      @(negedge clk);
      if (sck_o && !prev) begin
        bsr = {bsr[6:0], sdo};
        sdi = bsr[7];
      end
      prev = sck_o;
    end
    chk({tag, " R6 busy length"}, n, 16 * half);
    chk({tag, " R7 done in first idle cycle"}, done_irq, 1);
    @(negedge clk);
    chk({tag, " R7 done lasts one cycle"}, done_irq, 0);
    if (!rx_only) begin
      chk({tag, " R3 MSB-first transmit"}, bsr, tx);
      bus_read(2'd2, rd);
      chk({tag, " R3 received byte"}, rd, rxpat);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] got;
    logic [7:0] last_rx;
    int         d0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done_irq, 0);
    chk("R1 sck idle", sck_o, 1);
    chk("R1 sdo idle", sdo, 1);
    bus_read(2'd0, rd); chk("R1 ctrl", rd, 8'h00);
    bus_read(2'd1, rd); chk("R1 txbuf", rd, 8'h00);
    bus_read(2'd2, rd); chk("R1 shift", rd, 8'h00);

    // R2: register map
    bus_write(2'd0, 8'hC7); bus_read(2'd0, rd); chk("R2 ctrl readback", rd, 8'hC7);
    bus_write(2'd0, 8'h1F); bus_read(2'd0, rd); chk("R2 spare bits read 0", rd, 8'h07);
    bus_read(2'd3, rd); chk("R2 address 3", rd, 8'h00);
    bus_write(2'd2, 8'h55); bus_read(2'd2, rd); chk("R2 shift not writable", rd, 8'h00);

    // R5: disabled port
    bus_write(2'd0, 8'h40);
    bus_write(2'd1, 8'h5A);
    chk("R5 no start on write", busy, 0);
    bus_read(2'd1, rd); chk("R5 write still stored", rd, 8'h5A);
    bus_write(2'd0, 8'h00);
    bus_read(2'd2, rd);
    chk("R5 no start on read", busy, 0);

    // R3: exhaustive duplex sweep at the fastest divider
    bus_write(2'd0, 8'hC0);
    for (int v = 0; v < 256; v++) begin
      mxfer(8'(v), 8'(v * 37 + 11), 1'b0, 8'h00, 1, "R3 sweep");
    end

    // R6: divider sweep, select 7 behaves as 6
    for (int s = 0; s < 8; s++) begin
      bus_write(2'd0, 8'hC0 | 8'(s));
      mxfer(8'hA5 ^ 8'(s), 8'h5A + 8'(s), 1'b0, 8'h00, 1 << ((s > 6) ? 6 : s), "R6 divider");
    end
    last_rx = 8'h5A + 8'd7;

    // R4: receive-only chain
    bus_write(2'd0, 8'h80);
    bus_write(2'd1, 8'h11);
    chk("R4 write does not start", busy, 0);
    mxfer(8'h00, 8'hC3, 1'b1, last_rx, 1, "R4 rx1");
    mxfer(8'h00, 8'h2E, 1'b1, 8'hC3, 1, "R4 rx2");
    mxfer(8'h00, 8'h00, 1'b1, 8'h2E, 1, "R4 rx3");

    // R8: accesses while busy are dropped
    bus_write(2'd0, 8'hC3);
    sdi = 1'b0;
    bus_write(2'd1, 8'h81);
    bus_write(2'd1, 8'h3C);
    bus_write(2'd0, 8'h00);
    bus_read(2'd2, rd);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R8 no extra transfer", busy, 0);
    bus_read(2'd1, rd); chk("R8 txbuf kept", rd, 8'h81);
    bus_read(2'd0, rd); chk("R8 ctrl kept", rd, 8'hC3);
    bus_read(2'd2, rd); chk("R8 received zeros", rd, 8'h00);

    // R10: write in completion cycle is accepted
    bus_write(2'd0, 8'hC0);
    sdi = 1'b1;
    bus_write(2'd1, 8'h12);
    wait_idle();
    chk("R10 done seen", done_irq, 1);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h34;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R10 back-to-back start", busy, 1);
    wait_idle();
    bus_read(2'd1, rd); chk("R10 new byte stored", rd, 8'h34);
    bus_read(2'd2, rd); chk("R10 second transfer received", rd, 8'hFF);

    // R10/R8: write in the last busy cycle is dropped
    bus_write(2'd1, 8'h70);
    repeat (15) @(negedge clk);
    chk("R10 still busy in last cycle", busy, 1);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h0F;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R10 late write drops", busy, 0);
    @(negedge clk);
    chk("R10 no restart", busy, 0);
    bus_read(2'd1, rd); chk("R10 txbuf unchanged", rd, 8'h70);

    // R9: slave mode
    bus_write(2'd0, 8'hE0);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_write(2'd1, 8'h96);
    chk("R9 select high blocks start", busy, 0);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    d0 = done_cnt;
    bus_write(2'd1, 8'h96);
    chk("R9 select low starts", busy, 1);
    got = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      sck_i = 1'b0;
      sdi = 8'h4D >> i;
      repeat (4) @(negedge clk);
      got[i] = sdo;
      if (i == 4) chk("R9 sck_o held high", sck_o, 1);
      sck_i = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R9 one completion", done_cnt - d0, 1);
    chk("R9 idle after", busy, 0);
    chk("R9 slave transmit", got, 8'h96);
    bus_read(2'd2, rd); chk("R9 slave receive", rd, 8'h4D);
    ss_n = 1'b1;

    finish_run();
  end

endmodule